// File: doc/BRIEF.md
# Size-Adaptive ALU Flag Generator

This block performs add and subtract on two operands of up to 24 bits. It also produces the zero, carry, negative and overflow flags. The width at which the work is done changes with each instruction. Each operand and the destination carry a size code. The block picks the working width from those codes and keeps every flag true to that width, not to the full datapath.

An optional one-bit right shift can follow the ALU. When it is requested, the ALU carry-out does not go into the carry flag. It enters the top of the shifted field, and the bit that drops off the bottom becomes the carry flag.

The result is registered on every clock. The flags are registered only when the flag-update enable is high. Otherwise they keep their previous value.

Top module: `afu_flag_gen`

## Requirements
- R1: Size codes are 2 bits wide: 0 selects 8 bits, 1 selects 16 bits, 2 selects 24 bits, and the reserved code 3 is treated as 24 bits.
- R2: The working width is the smaller of the destination width and the wider of the two source widths. An 8-bit destination always gives an 8-bit operation. Two 8-bit sources always give an 8-bit operation.
- R3: With op_sub low, the low working-width bits of result equal (a + b + carry_in) modulo 2^width, using only the low working-width bits of each operand. All result bits above the working width are zero. The result appears one clock after the inputs.
- R4: With op_sub high, the low working-width bits of result equal (a - b - carry_in) modulo 2^width. Here carry_in acts as a borrow-in, and the carry flag is set when a borrow occurs out of the working width.
- R5: flag_z is set when the registered result is all zero. flag_n equals result bit (width - 1).
- R6: Without a shift, flag_c for an add is the carry out of bit (width - 1). flag_v is set on two's-complement overflow at the working width.
- R7: With shift_en high, the result field becomes {alu_carry, sum[width-1:1]} and flag_c takes sum[0]. alu_carry is the add carry or the subtract borrow. Z and N follow the shifted field, and V still reports the ALU overflow.
- R8: With flag_en low, all four flags keep their previous values while the result still updates.
- R9: A synchronous active-high rst clears the result and all four flags on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 24 | A operand |
| b_in | input | 24 | B operand |
| a_sz | input | 2 | A source size code |
| b_sz | input | 2 | B source size code |
| d_sz | input | 2 | Destination size code |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Carry-in for add, borrow-in for subtract |
| shift_en | input | 1 | Post-ALU one-bit right shift request |
| flag_en | input | 1 | Flag register update enable |
| result | output | 24 | Registered result, zero above the working width |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Two functions can act in the same cycle: an ALU carry-out and a shift request. The carry has to land in the result field while the carry flag takes the low sum bit instead.

Directed cases cover both combinations. One has a carry with an even sum (0xFF + 0x01 at 8 bits). The other has no carry with an odd sum. Random cycles then mix shift, size codes and subtraction.

A cycle-accurate behavioural model in the bench judges every cycle. It compares the result bus and all four flags one clock after each input set.

// File: rtl/afu_pkg.sv
package afu_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } flags_t;
endpackage

// File: rtl/afu_size_sel.sv
module afu_size_sel #(
  parameter int LANES = 3,
  parameter int SZW   = 2
) (
  input  logic [SZW-1:0] a_sz,
  input  logic [SZW-1:0] b_sz,
  input  logic [SZW-1:0] d_sz,
  output logic [SZW-1:0] op_sz
);
  localparam logic [SZW-1:0] TOP_CODE = SZW'(LANES - 1);

  logic [SZW-1:0] a_c, b_c, d_c, src_max;

  // Codes beyond the widest lane fall back to the widest lane
  always_comb begin
    a_c     = (a_sz > TOP_CODE) ? TOP_CODE : a_sz;
    b_c     = (b_sz > TOP_CODE) ? TOP_CODE : b_sz;
    d_c     = (d_sz > TOP_CODE) ? TOP_CODE : d_sz;
    src_max = (a_c > b_c) ? a_c : b_c;
    op_sz   = (d_c < src_max) ? d_c : src_max;
  end
endmodule

// File: rtl/afu_lane.sv
module afu_lane #(
  parameter int W  = 8,
  parameter int DW = 24
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          sub,
  input  logic          cin,
  input  logic          shift,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o
);
  logic [W:0]   t;
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic         alu_c;
  logic [W-1:0] r;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    t     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    alu_c = sub ? ~t[W] : t[W];
    v_o   = (a[W-1] == b_eff[W-1]) && (t[W-1] != a[W-1]);
    if (shift) begin
      r   = {alu_c, t[W-1:1]};
      c_o = t[0];
    end else begin
      r   = t[W-1:0];
      c_o = alu_c;
    end
    res_o = DW'(r);
  end
endmodule

// File: rtl/afu_flag_gen.sv
module afu_flag_gen #(
  parameter int LANE_W = 8,
  parameter int LANES  = 3,
  parameter int SZW    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANE_W*LANES-1:0] a_in,
  input  logic [LANE_W*LANES-1:0] b_in,
  input  logic [SZW-1:0]          a_sz,
  input  logic [SZW-1:0]          b_sz,
  input  logic [SZW-1:0]          d_sz,
  input  logic                    op_sub,
  input  logic                    carry_in,
  input  logic                    shift_en,
  input  logic                    flag_en,
  output logic [LANE_W*LANES-1:0] result,
  output logic                    flag_z,
  output logic                    flag_c,
  output logic                    flag_n,
  output logic                    flag_v
);
  import afu_pkg::*;

  localparam int DW = LANE_W * LANES;

  logic [SZW-1:0] op_sz;
  logic [DW-1:0]  lane_res [LANES];
  logic           lane_c   [LANES];
  logic           lane_v   [LANES];
  logic [DW-1:0]  sel_res;
  logic           sel_n, sel_c, sel_v;
  alu_op_e        op;
  flags_t         flags_d, flags_q;

  assign op = op_sub ? OP_SUB : OP_ADD;

  afu_size_sel #(.LANES(LANES), .SZW(SZW)) u_size (
    .a_sz (a_sz),
    .b_sz (b_sz),
    .d_sz (d_sz),
    .op_sz(op_sz)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g + 1) * LANE_W;
    afu_lane #(.W(LW), .DW(DW)) u_lane (
      .a    (a_in[LW-1:0]),
      .b    (b_in[LW-1:0]),
      .sub  (op == OP_SUB),
      .cin  (carry_in),
      .shift(shift_en),
      .res_o(lane_res[g]),
      .c_o  (lane_c[g]),
      .v_o  (lane_v[g])
    );
  end

  always_comb begin
    sel_res = '0;
    sel_n   = 1'b0;
    sel_c   = 1'b0;
    sel_v   = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (op_sz == SZW'(k)) begin
        sel_res = lane_res[k];
        sel_n   = lane_res[k][(k+1)*LANE_W-1];
        sel_c   = lane_c[k];
        sel_v   = lane_v[k];
      end
    end
    flags_d.z = (sel_res == '0);
    flags_d.c = sel_c;
    flags_d.n = sel_n;
    flags_d.v = sel_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      flags_q <= '0;
    end else begin
      result <= sel_res;
      if (flag_en) flags_q <= flags_d;
    end
  end

  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;
endmodule

// File: rtl/afu_flag_chk.sv
module afu_flag_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 3,
  parameter int SZW    = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    flag_en,
  input logic [SZW-1:0]          d_sz,
  input logic [SZW-1:0]          op_sz,
  input logic [LANE_W*LANES-1:0] result,
  input logic                    flag_z,
  input logic                    flag_c,
  input logic                    flag_n,
  input logic                    flag_v
);
  localparam int DW = LANE_W * LANES;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result == '0 && {flag_z, flag_c, flag_n, flag_v} == 4'b0)); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> $stable({flag_z, flag_c, flag_n, flag_v})); // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> (flag_z == (result == '0))); // R5

  AST_NEG_NARROW: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op_sz == '0) |=> (flag_n == result[LANE_W-1])); // R5

  AST_DEST_NARROW: assert property (@(posedge clk) disable iff (rst)
    (d_sz == '0) |=> (result[DW-1:LANE_W] == '0)); // R2
endmodule

bind afu_flag_gen afu_flag_chk #(.LANE_W(LANE_W), .LANES(LANES), .SZW(SZW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .flag_en(flag_en),
  .d_sz   (d_sz),
  .op_sz  (op_sz),
  .result (result),
  .flag_z (flag_z),
  .flag_c (flag_c),
  .flag_n (flag_n),
  .flag_v (flag_v)
);

// File: tb/afu_flag_gen_tb.sv
module afu_flag_gen_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] a_in = '0, b_in = '0;
  logic [1:0]  a_sz = '0, b_sz = '0, d_sz = '0;
  logic        op_sub = 1'b0, carry_in = 1'b0, shift_en = 1'b0, flag_en = 1'b0;
  logic [23:0] result;
  logic        flag_z, flag_c, flag_n, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint exp_res = 0;
  bit ez = 0, ec = 0, en = 0, ev = 0;

  always #(PERIOD/2) clk = ~clk;

  afu_flag_gen u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .a_sz(a_sz), .b_sz(b_sz), .d_sz(d_sz),
    .op_sub(op_sub), .carry_in(carry_in), .shift_en(shift_en), .flag_en(flag_en),
    .result(result), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v)
  );

  function automatic int width_of(int code);
    return (code >= 2) ? 24 : (code + 1) * 8;
  endfunction

  // Behavioural model of one clock
  task automatic model();
    int w, wa, wb, wd;
    longint mask, sa, sb, t, s, r;
    bit alu_c, vv, cc;
    if (rst) begin
      exp_res = 0; ez = 0; ec = 0; en = 0; ev = 0;
      return;
    end
    wa = width_of(a_sz); wb = width_of(b_sz); wd = width_of(d_sz);
    w = (wa > wb) ? wa : wb;
    if (wd < w) w = wd;
    mask = (longint'(1) << w) - 1;
    sa = longint'(a_in) & mask;
    sb = longint'(b_in) & mask;
    if (!op_sub) begin
      t = sa + sb + longint'(carry_in);
      alu_c = t[w];
      s = t & mask;
      vv = (sa[w-1] == sb[w-1]) && (s[w-1] != sa[w-1]);
    end else begin
      t = sa - sb - longint'(carry_in);
      alu_c = (t < 0);
      s = t & mask;
      vv = (sa[w-1] != sb[w-1]) && (s[w-1] != sa[w-1]);
    end
    if (shift_en) begin
      r  = (longint'(alu_c) << (w - 1)) | (s >> 1);
      cc = s[0];
    end else begin
      r  = s;
      cc = alu_c;
    end
    exp_res = r;
    if (flag_en) begin
      ez = (r == 0); en = r[w-1]; ec = cc; ev = vv;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (longint'(result) != exp_res) begin
      errors++;
      $display("FAIL %s result got %h exp %h", tag, result, exp_res[23:0]);
    end
    checks++;
    if ({flag_z, flag_c, flag_n, flag_v} != {ez, ec, en, ev}) begin
      errors++;
      $display("FAIL %s flags zcnv got %b exp %b", tag,
               {flag_z, flag_c, flag_n, flag_v}, {ez, ec, en, ev});
    end
  endtask

  task automatic step(input logic [23:0] a, input logic [23:0] b,
                      input logic [1:0] as, input logic [1:0] bs, input logic [1:0] ds,
                      input logic sb, input logic ci, input logic sh, input logic fe,
                      input logic rs, input string tag);
    a_in = a; b_in = b; a_sz = as; b_sz = bs; d_sz = ds;
    op_sub = sb; carry_in = ci; shift_en = sh; flag_en = fe; rst = rs;
    @(posedge clk);
    model();
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(24'h123456, 24'h654321, 2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 reset");
    // R2: 8-bit destination with 24-bit sources -> 8-bit carry, zero, overflow
    step(24'hFFFF80, 24'h000080, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 dest8");
    // R2: 8-bit sources into 24-bit destination
    step(24'h1234FF, 24'h000001, 2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 src8");
    // R6: 16-bit sources, 24-bit destination -> carry out of bit 15
    step(24'h00FFFF, 24'h000001, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 w16 carry");
    // R3: 24-bit source with 24-bit destination, no carry
    step(24'h00FFFF, 24'h000001, 2'd2, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 w24 add");
    // R1: reserved code 3 acts as 24 bits
    step(24'hFFFFFF, 24'h000001, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 code3");
    // R4: borrow at 8 bits
    step(24'h000000, 24'h000001, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 borrow");
    // R4: signed overflow on subtract with borrow-in
    step(24'h000080, 24'h000000, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4 sub ovf");
    // R5: negative at 16 bits
    step(24'h008000, 24'h000000, 2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 neg16");
    // R7: carry plus shift in the same cycle
    step(24'h0000FF, 24'h000001, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 carry+shift");
    // R7: odd sum, no carry, shifted
    step(24'h000003, 24'h000000, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 odd shift");
    // R8: flags frozen while the result moves
    step(24'h000000, 24'h000000, 2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 hold");
    step(24'h800000, 24'h800000, 2'd2, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 hold2");
    // R9: reset in mid-run
    step(24'hFFFFFF, 24'hFFFFFF, 2'd2, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9 midreset");
    for (int i = 0; i < 400; i++) begin
      step($urandom, $urandom, 2'($urandom), 2'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0),
           1'(i % 97 == 50), "R3/R4/R6/R7 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule